// File: doc/BRIEF.md
# Dual-Mode PCS Lane Multiplexer

This block steers data between 16-bit internal PCS lanes and 80-bit SerDes words, for a parameterised number of SerDes interfaces (four by default). It works in both directions. On transmit it packs per-lane words into one SerDes word per interface. On receive it unpacks a SerDes word back into lane words. A single mode input picks the lane ratio for all interfaces at once. In the wide mode, five PCS lanes fill the whole 80-bit word (5:1). In the narrow mode, two PCS lanes fill a 32-bit physical lane held in the low bits of the word (2:1).

PCS lane `l` of an interface always sits at bits `[16*l+15 : 16*l]` of that interface's 80-bit word, and interface `i` sits at bits `[80*i+79 : 80*i]` of the flattened buses. A mode change passes through a small state machine. It has two run states, `ST_WIDE` and `ST_NARROW`, and two one-cycle settle states, `ST_TO_WIDE` and `ST_TO_NARROW`.

The transitions are as follows:
- `ST_WIDE` moves to `ST_TO_NARROW` when the mode input asks for narrow.
- `ST_NARROW` moves to `ST_TO_WIDE` when the mode input asks for wide.
- `ST_TO_NARROW` moves to `ST_NARROW` if narrow is still requested, or to `ST_TO_WIDE` if it is not.
- `ST_TO_WIDE` moves to `ST_WIDE` if wide is still requested, or to `ST_TO_NARROW` if it is not.
- A run state whose mode matches the input stays where it is.

In a settle state, nothing is accepted in either direction.

Top module: `pcs_lane_steer`

## Requirements
- R1: While reset is low, and on the first cycle after it is released with idle inputs, `tx_word_valid_o` is 0, `tx_word_o` is all zero, `rx_lane_valid_o` is 0 and `rx_lane_data_o` is all zero. The block comes out of reset in the wide mode.
- R2: In the wide mode (mode input 0), with `tx_lane_valid_i` high at a clock edge, the next cycle shows `tx_word_valid_o`=1. In that cycle, `tx_word_o` equals `tx_lane_data_i` as sampled: lane `l` of interface `i` is at bits `[80*i+16*l +: 16]`.
- R3: In the narrow mode (mode input 1), transmit lanes 0 and 1 land in bits `[31:0]` of each interface word and bits `[79:32]` are zero. Lanes 2 to 4 have no effect on the output.
- R4: A clock edge with `tx_lane_valid_i` low gives `tx_word_valid_o`=0 and an all-zero `tx_word_o` in the next cycle.
- R5: A mode-input value that differs from the active mode at an edge does not affect that edge: its data is still handled in the old mode. The next edge is a dead edge: transmit and receive data presented there are dropped. The new mode applies from the edge after that.
- R6: In the wide mode, an 80-bit word presented with `rx_word_valid_i` high is registered at edge k. After edge k+1, `rx_lane_valid_o`=5'b11111 and lane `l` of `rx_lane_data_o` holds word bits `[16*l +: 16]`.
- R7: In the narrow mode, a received word gives `rx_lane_valid_o`=5'b00011, with lanes 0 and 1 taken from bits `[31:0]`. Lanes 2 to 4 read zero, and word bits `[79:32]` have no effect.
- R8: A received word presented with `rx_word_valid_i` low gives `rx_lane_valid_o`=0 and all-zero lane data two edges later.
- R9: Each interface is packed and unpacked independently from its own slice of every bus. No data crosses between interfaces.
- R10: If the mode input changes again during a dead edge, a further dead edge follows before the mode it finally settles on applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_narrow_i | input | 1 | Requested mode: 0 wide (5:1), 1 narrow (2:1) |
| tx_lane_data_i | input | NUM_IFC*80 | Transmit PCS lane words, 16 bits per lane, 5 lanes per interface |
| tx_lane_valid_i | input | 1 | Transmit lane words valid this cycle |
| tx_word_o | output | NUM_IFC*80 | Packed SerDes words, one per interface |
| tx_word_valid_o | output | 1 | `tx_word_o` carries data |
| rx_word_i | input | NUM_IFC*80 | Received SerDes words, one per interface |
| rx_word_valid_i | input | 1 | `rx_word_i` carries data this cycle |
| rx_lane_data_o | output | NUM_IFC*80 | Unpacked receive PCS lane words |
| rx_lane_valid_o | output | 5 | Per-lane receive valid, shared by all interfaces |

## Verification
The assertions assume that reset is applied before the first clock edge and that the mode input changes only between clock edges. They also assume the data buses are driven to known values whenever their valid strobes are high. The stimulus changes every input at the falling clock edge and keeps reset low for several cycles at the start. It switches mode while traffic is running, including a flip back during a dead cycle. It randomises the receive bits that the narrow mode must ignore and the transmit lanes that the narrow mode must ignore.

// File: rtl/pcs_lane_steer_pkg.sv
package pcs_lane_steer_pkg;

    // Mode controller states: two run states and two one-cycle settle states
    typedef enum logic [1:0] {
        ST_WIDE      = 2'd0,
        ST_NARROW    = 2'd1,
        ST_TO_WIDE   = 2'd2,
        ST_TO_NARROW = 2'd3
    } steer_state_e;

endpackage

// File: rtl/pcs_mode_fsm.sv
module pcs_mode_fsm
    import pcs_lane_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_narrow_i,
    output logic run_o,
    output logic narrow_o
);

    steer_state_e state_q;
    steer_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WIDE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a request that differs from the active mode always costs one settle cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WIDE:      state_d = mode_narrow_i ? ST_TO_NARROW : ST_WIDE;
            ST_NARROW:    state_d = mode_narrow_i ? ST_NARROW    : ST_TO_WIDE;
            ST_TO_NARROW: state_d = mode_narrow_i ? ST_NARROW    : ST_TO_WIDE;
            ST_TO_WIDE:   state_d = mode_narrow_i ? ST_TO_NARROW : ST_WIDE;
        endcase
    end

    // Outputs decoded from the state register alone
    always_comb begin
        run_o    = 1'b0;
        narrow_o = 1'b0;
        unique case (state_q)
            ST_WIDE: begin
                run_o    = 1'b1;
            end
            ST_NARROW: begin
                run_o    = 1'b1;
                narrow_o = 1'b1;
            end
            ST_TO_WIDE: begin
                run_o    = 1'b0;
            end
            ST_TO_NARROW: begin
                narrow_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pcs_tx_pack.sv
module pcs_tx_pack #(
    parameter int LANE_W = 16,
    parameter int LANES  = 5,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [WORD_W-1:0] lanes_i,
    output logic [WORD_W-1:0] word_o
);

    logic [LANE_W-1:0] slot_q [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_slot
        // A disabled slot is forced to zero, which also blanks the unused high part in narrow mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[l] <= '0;
            end else begin
                slot_q[l] <= lane_en_i[l] ? lanes_i[l*LANE_W +: LANE_W] : '0;
            end
        end
        assign word_o[l*LANE_W +: LANE_W] = slot_q[l];
    end

endmodule

// File: rtl/pcs_rx_unpack.sv
module pcs_rx_unpack #(
    parameter int LANE_W = 16,
    parameter int LANES  = 5,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANES-1:0]  lane_en_i,
    output logic [WORD_W-1:0] lanes_o
);

    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q [LANES];

    // First stage: register the SerDes word as received
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_i;
        end
    end

    // Second stage: fan the registered word out to the enabled lanes
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[l] <= '0;
            end else begin
                lane_q[l] <= lane_en_i[l] ? word_q[l*LANE_W +: LANE_W] : '0;
            end
        end
        assign lanes_o[l*LANE_W +: LANE_W] = lane_q[l];
    end

endmodule

// File: rtl/pcs_lane_steer.sv
module pcs_lane_steer #(
    parameter int NUM_IFC      = 4,
    parameter int LANE_W       = 16,
    parameter int LANES_WIDE   = 5,
    parameter int LANES_NARROW = 2,
    localparam int WORD_W = LANE_W * LANES_WIDE,
    localparam int BUS_W  = NUM_IFC * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_narrow_i,
    input  logic [BUS_W-1:0]      tx_lane_data_i,
    input  logic                  tx_lane_valid_i,
    output logic [BUS_W-1:0]      tx_word_o,
    output logic                  tx_word_valid_o,
    input  logic [BUS_W-1:0]      rx_word_i,
    input  logic                  rx_word_valid_i,
    output logic [BUS_W-1:0]      rx_lane_data_o,
    output logic [LANES_WIDE-1:0] rx_lane_valid_o
);

    logic                  fsm_run;
    logic                  fsm_narrow;
    logic [LANES_WIDE-1:0] tx_lane_en;
    logic [LANES_WIDE-1:0] rx_lane_en;
    logic                  tx_valid_q;
    logic                  rx_cap_vld_q;
    logic                  rx_cap_narrow_q;
    logic [LANES_WIDE-1:0] rx_valid_q;

    pcs_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_narrow_i(mode_narrow_i),
        .run_o        (fsm_run),
        .narrow_o     (fsm_narrow)
    );

    // Lane enables: transmit from the live mode, receive from the mode captured with the word
    always_comb begin
        for (int l = 0; l < LANES_WIDE; l++) begin
            tx_lane_en[l] = fsm_run && tx_lane_valid_i && (!fsm_narrow || (l < LANES_NARROW));
            rx_lane_en[l] = rx_cap_vld_q && (!rx_cap_narrow_q || (l < LANES_NARROW));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid_q      <= 1'b0;
            rx_cap_vld_q    <= 1'b0;
            rx_cap_narrow_q <= 1'b0;
            rx_valid_q      <= '0;
        end else begin
            tx_valid_q      <= fsm_run && tx_lane_valid_i;
            rx_cap_vld_q    <= fsm_run && rx_word_valid_i;
            rx_cap_narrow_q <= fsm_narrow;
            rx_valid_q      <= rx_lane_en;
        end
    end

    assign tx_word_valid_o = tx_valid_q;
    assign rx_lane_valid_o = rx_valid_q;

    for (genvar i = 0; i < NUM_IFC; i++) begin : g_ifc
        pcs_tx_pack #(
            .LANE_W(LANE_W),
            .LANES (LANES_WIDE)
        ) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .lane_en_i(tx_lane_en),
            .lanes_i  (tx_lane_data_i[i*WORD_W +: WORD_W]),
            .word_o   (tx_word_o[i*WORD_W +: WORD_W])
        );

        pcs_rx_unpack #(
            .LANE_W(LANE_W),
            .LANES (LANES_WIDE)
        ) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .word_i   (rx_word_i[i*WORD_W +: WORD_W]),
            .lane_en_i(rx_lane_en),
            .lanes_o  (rx_lane_data_o[i*WORD_W +: WORD_W])
        );
    end

endmodule

// File: rtl/pcs_lane_steer_chk.sv
module pcs_lane_steer_chk #(
    parameter int NUM_IFC      = 4,
    parameter int LANE_W       = 16,
    parameter int LANES_WIDE   = 5,
    parameter int LANES_NARROW = 2,
    localparam int WORD_W   = LANE_W * LANES_WIDE,
    localparam int NARROW_W = LANE_W * LANES_NARROW,
    localparam int BUS_W    = NUM_IFC * WORD_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mode_narrow_i,
    input logic                  run,
    input logic                  narrow,
    input logic [BUS_W-1:0]      tx_lane_data_i,
    input logic                  tx_lane_valid_i,
    input logic [BUS_W-1:0]      tx_word_o,
    input logic                  tx_word_valid_o,
    input logic [BUS_W-1:0]      rx_word_i,
    input logic                  rx_word_valid_i,
    input logic [BUS_W-1:0]      rx_lane_data_o,
    input logic [LANES_WIDE-1:0] rx_lane_valid_o
);

    localparam logic [LANES_WIDE-1:0] NARROW_MASK = LANES_WIDE'((1 << LANES_NARROW) - 1);

    logic upper_zero;
    always_comb begin
        upper_zero = 1'b1;
        for (int i = 0; i < NUM_IFC; i++) begin
            if (tx_word_o[i*WORD_W + NARROW_W +: WORD_W - NARROW_W] != '0) begin
                upper_zero = 1'b0;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!tx_word_valid_o && rx_lane_valid_o == '0));

    p_tx_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !narrow && tx_lane_valid_i) |=> (tx_word_valid_o && tx_word_o == $past(tx_lane_data_i)));

    p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && narrow && tx_lane_valid_i) |=> (tx_word_valid_o && upper_zero));

    p_tx_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_lane_valid_i |=> !tx_word_valid_o);

    p_flip_gives_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (mode_narrow_i != narrow)) |=> !run);

    p_dead_drops_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tx_word_valid_o);

    p_rx_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !narrow && rx_word_valid_i) |=> ##1
        (rx_lane_valid_o == '1 && rx_lane_data_o == $past(rx_word_i, 2)));

    p_rx_lane_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lane_valid_o == '0) || (rx_lane_valid_o == NARROW_MASK) || (rx_lane_valid_o == '1));

    p_rx_needs_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lane_valid_o != '0) |-> $past(rx_word_valid_i, 2));

    p_reflip_dead_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && (mode_narrow_i != narrow)) |=> !run);

endmodule

bind pcs_lane_steer pcs_lane_steer_chk #(
    .NUM_IFC     (NUM_IFC),
    .LANE_W      (LANE_W),
    .LANES_WIDE  (LANES_WIDE),
    .LANES_NARROW(LANES_NARROW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_narrow_i  (mode_narrow_i),
    .run            (fsm_run),
    .narrow         (fsm_narrow),
    .tx_lane_data_i (tx_lane_data_i),
    .tx_lane_valid_i(tx_lane_valid_i),
    .tx_word_o      (tx_word_o),
    .tx_word_valid_o(tx_word_valid_o),
    .rx_word_i      (rx_word_i),
    .rx_word_valid_i(rx_word_valid_i),
    .rx_lane_data_o (rx_lane_data_o),
    .rx_lane_valid_o(rx_lane_valid_o)
);

// File: tb/pcs_lane_steer_bench.sv
`timescale 1ns/1ps
module pcs_lane_steer_bench;

    localparam int NIFC = 4;
    localparam int LW   = 16;
    localparam int NL   = 5;
    localparam int NN   = 2;
    localparam int WW   = LW * NL;
    localparam int BW   = NIFC * WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          mode_narrow_i = 1'b0;
    logic [BW-1:0] tx_lane_data_i = '0;
    logic          tx_lane_valid_i = 1'b0;
    logic [BW-1:0] tx_word_o;
    logic          tx_word_valid_o;
    logic [BW-1:0] rx_word_i = '0;
    logic          rx_word_valid_i = 1'b0;
    logic [BW-1:0] rx_lane_data_o;
    logic [NL-1:0] rx_lane_valid_o;

    int checks = 0;
    int failures = 0;

    // Reference model state
    logic          m_narrow = 1'b0;
    logic          m_dead   = 1'b0;
    logic          c_vld    = 1'b0;
    logic          c_nar    = 1'b0;
    logic [BW-1:0] c_word   = '0;
    logic          e_txv    = 1'b0;
    logic [BW-1:0] e_txw    = '0;
    logic [NL-1:0] e_rxv    = '0;
    logic [BW-1:0] e_rxd    = '0;

    always #2.5 clk = ~clk;

    pcs_lane_steer u_pcs_lane_steer (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_narrow_i  (mode_narrow_i),
        .tx_lane_data_i (tx_lane_data_i),
        .tx_lane_valid_i(tx_lane_valid_i),
        .tx_word_o      (tx_word_o),
        .tx_word_valid_o(tx_word_valid_o),
        .rx_word_i      (rx_word_i),
        .rx_word_valid_i(rx_word_valid_i),
        .rx_lane_data_o (rx_lane_data_o),
        .rx_lane_valid_o(rx_lane_valid_o)
    );

    function automatic logic [BW-1:0] rnd_bus();
        logic [BW-1:0] v;
        for (int k = 0; k < BW / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [BW-1:0] tag_bus(input logic [3:0] salt);
        logic [BW-1:0] v;
        for (int i = 0; i < NIFC; i++)
            for (int l = 0; l < NL; l++)
                v[i*WW + l*LW +: LW] = {salt, 4'(i), 4'hC, 4'(l)};
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "tx_word_valid", BW'(tx_word_valid_o), BW'(e_txv));
        chk(req, "tx_word", tx_word_o, e_txw);
        chk(req, "rx_lane_valid", BW'(rx_lane_valid_o), BW'(e_rxv));
        chk(req, "rx_lane_data", rx_lane_data_o, e_rxd);
    endtask

    // One cycle: check outputs of the previous edge, drive new inputs, predict the next edge
    task automatic step(input string req, input logic mode, input logic txv, input logic [BW-1:0] txd,
                        input logic rxv, input logic [BW-1:0] rxd);
        logic run;
        @(negedge clk);
        compare(req);
        mode_narrow_i   = mode;
        tx_lane_valid_i = txv;
        tx_lane_data_i  = txd;
        rx_word_valid_i = rxv;
        rx_word_i       = rxd;
        run = !m_dead;
        e_txv = run && txv;
        e_txw = '0;
        e_rxd = '0;
        for (int l = 0; l < NL; l++) begin
            e_rxv[l] = c_vld && (!c_nar || l < NN);
            for (int i = 0; i < NIFC; i++) begin
                if (run && txv && (!m_narrow || l < NN))
                    e_txw[i*WW + l*LW +: LW] = txd[i*WW + l*LW +: LW];
                if (e_rxv[l])
                    e_rxd[i*WW + l*LW +: LW] = c_word[i*WW + l*LW +: LW];
            end
        end
        c_vld  = run && rxv;
        c_nar  = m_narrow;
        c_word = rxd;
        if (mode != m_narrow) begin
            m_narrow = mode;
            m_dead   = 1'b1;
        end else begin
            m_dead   = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        // R1: quiet outputs during reset
        repeat (3) begin
            @(negedge clk);
            compare("R1");
        end
        rst_n = 1'b1;
        step("R1", 1'b0, 1'b0, '0, 1'b0, '0);
        // R2 / R6: wide traffic both directions
        for (int n = 0; n < 6; n++) step("R2", 1'b0, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        for (int n = 0; n < 4; n++) step("R6", 1'b0, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        // R4 / R8: strobes low with random data present
        for (int n = 0; n < 3; n++) step("R4", 1'b0, 1'b0, rnd_bus(), 1'b0, rnd_bus());
        for (int n = 0; n < 3; n++) step("R8", 1'b0, (n == 1), rnd_bus(), (n == 1), rnd_bus());
        // R5: switch to narrow while traffic runs
        for (int n = 0; n < 3; n++) step("R5", 1'b1, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        // R3 / R7: narrow traffic with random unused lanes and upper bits
        for (int n = 0; n < 6; n++) step("R3", 1'b1, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        for (int n = 0; n < 5; n++) step("R7", 1'b1, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        // R10: flip to wide, then back to narrow during the dead cycle
        step("R10", 1'b0, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        step("R10", 1'b1, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        for (int n = 0; n < 4; n++) step("R10", 1'b1, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        // R5: back to wide
        for (int n = 0; n < 3; n++) step("R5", 1'b0, 1'b1, rnd_bus(), 1'b1, rnd_bus());
        // R9: per-interface tagged patterns in both modes
        for (int n = 0; n < 4; n++) step("R9", 1'b0, 1'b1, tag_bus(4'(n)), 1'b1, tag_bus(4'(n + 8)));
        for (int n = 0; n < 6; n++) step("R9", 1'b1, 1'b1, tag_bus(4'(n)), 1'b1, tag_bus(4'(n + 8)));
        // R8: drain
        for (int n = 0; n < 3; n++) step("R8", 1'b1, 1'b0, '0, 1'b0, '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule